// File: doc/BRIEF.md
# Two-Stage Periodic Interrupt Timer

This block produces periodic timeouts from a two-level count chain. Two 8-bit prescaler down-counters, the base counters, each produce a one-cycle tick when they pass zero. Four 16-bit channel down-counters each follow one of the two bases. A channel steps down once per tick of its base. When it passes zero, it reloads its own period value, sets its timeout flag and, if its interrupt enable is set, asserts its interrupt line. With base load M and channel load N, the channel times out every (M+1)*(N+1) clocks.

Software drives the block through a plain synchronous port. A write is taken on the clock edge where `wr_en` is high. A read is combinational from `addr`. A global run bit gates the whole block. Two mode inputs, a low-power wait indication and a debug halt indication, can stall counting when the matching control bit is set. A base can be restarted at any time with a force-load command, and this shifts the timing of every channel that follows that base.

Top module: `pit_timer`

## Requirements
- R1: Register map on `addr`. 0 is control. 1 is channel enable, bit i for channel i. 2 is base select, bit i picks base 1 for channel i when set and base 0 when clear. 3 is interrupt enable, bit i. 4 is flags, bit i. 5 and 6 are the base loads for base 0 and base 1. 8 to 11 are the channel loads for channels 0 to 3. After reset every register reads zero and `irq` is zero.
- R2: While the control run bit (bit 7) is clear, no channel counts and every flag is cleared, with the flags reading zero from the cycle after the run bit is cleared.
- R3: Setting the run bit starts every enabled channel and its base from their load values, so the first timeout is flagged (M+1)*(N+1) clocks after the enabling write.
- R4: After the first timeout, an enabled channel flags again every (M+1)*(N+1) clocks.
- R5: A channel whose enable bit is clear never sets its flag.
- R6: While control bit 6 is set and `wait_mode` is high, all counters hold, which delays each timeout by the stalled cycles. With bit 6 clear, `wait_mode` has no effect.
- R7: While control bit 5 is set and `dbg_freeze` is high, all counters hold. With bit 5 clear, `dbg_freeze` has no effect.
- R8: Writing one to control bit 0 or bit 1 restarts base 0 or base 1 from its load value. This happens only when the run bit was already set and at least one enabled channel selects that base. Otherwise the command is ignored, and an unused base holds its count.
- R9: A base restart shifts the timing of every enabled channel that follows that base.
- R10: Control bits 4 to 0 always read as zero. Bits 7 to 5 read back as written.
- R11: Writing ones to the flag register clears those flags. Zero bits leave flags unchanged.
- R12: `irq[i]` is high exactly while flag i and interrupt enable i are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| wait_mode | input | 1 | Low-power wait indication |
| dbg_freeze | input | 1 | Debug halt indication |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The assertions check properties that must hold on every cycle. Flags stay clear while the block is off. A flag can only rise for a channel that was enabled. The control read-back never shows the command bits. Every base and channel count is frozen while an enabled wait or debug stall is in force. The exact period arithmetic can only be shown by the bench scenarios, which time the interrupt edges. The same holds for the shift caused by a base restart across two channels on one base, the refusal of a restart on an unused base, and the clear-on-write and interrupt-masking behaviour.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_CHEN     = 4'd1;
    localparam logic [ADDR_W-1:0] A_BSEL     = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN      = 4'd3;
    localparam logic [ADDR_W-1:0] A_FLAG     = 4'd4;
    localparam int                A_MLD_BASE = 5;
    localparam int                A_CLD_BASE = 8;

    localparam int B_RUN   = 7;
    localparam int B_SWAIT = 6;
    localparam int B_FRZ   = 5;

    typedef struct packed {
        logic run;
        logic stop_wait;
        logic frz_stall;
    } ctrl_t;

    function automatic int sel_width(input int n_bases);
        return (n_bases > 1) ? $clog2(n_bases) : 1;
    endfunction

endpackage

// File: rtl/pit_regs.sv
`timescale 1ns/1ps
module pit_regs
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NUM_MT = 2,
    parameter int MT_W   = 8,
    parameter int CH_W   = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [NUM_CH-1:0]                ch_hit,
    output logic [DATA_W-1:0]                rdata,
    output ctrl_t                            ctrl,
    output logic [NUM_CH-1:0]                chen,
    output logic [NUM_CH*sel_width(NUM_MT)-1:0] bsel,
    output logic [NUM_CH-1:0]                ien,
    output logic [NUM_CH-1:0]                flag,
    output logic [NUM_MT-1:0][MT_W-1:0]      mld,
    output logic [NUM_CH-1:0][CH_W-1:0]      cld,
    output logic [NUM_MT-1:0]                force_cmd
);
    localparam int SEL_W = sel_width(NUM_MT);
    localparam int BS_W  = NUM_CH * SEL_W;

    logic wr_ctrl, wr_chen, wr_bsel, wr_ien, wr_flag;
    logic [NUM_CH-1:0] w1c;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_chen = wr_en && (addr == A_CHEN);
    assign wr_bsel = wr_en && (addr == A_BSEL);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign wr_flag = wr_en && (addr == A_FLAG);
    assign w1c     = wr_flag ? wdata[NUM_CH-1:0] : '0;
    assign force_cmd = wr_ctrl ? wdata[NUM_MT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            chen <= '0;
            bsel <= '0;
            ien  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run       <= wdata[B_RUN];
                ctrl.stop_wait <= wdata[B_SWAIT];
                ctrl.frz_stall <= wdata[B_FRZ];
            end
            if (wr_chen) chen <= wdata[NUM_CH-1:0];
            if (wr_bsel) bsel <= wdata[BS_W-1:0];
            if (wr_ien)  ien  <= wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run) flag <= '0;
        else                  flag <= (flag & ~w1c) | ch_hit;
    end

    for (genvar m = 0; m < NUM_MT; m++) begin : g_mld
        always_ff @(posedge clk) begin
            if (rst) mld[m] <= '0;
            else if (wr_en && addr == ADDR_W'(A_MLD_BASE + m)) mld[m] <= wdata[MT_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cld
        always_ff @(posedge clk) begin
            if (rst) cld[c] <= '0;
            else if (wr_en && addr == ADDR_W'(A_CLD_BASE + c)) cld[c] <= wdata[CH_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_RUN]   = ctrl.run;
                rdata[B_SWAIT] = ctrl.stop_wait;
                rdata[B_FRZ]   = ctrl.frz_stall;
            end
            A_CHEN: rdata = DATA_W'(chen);
            A_BSEL: rdata = DATA_W'(bsel);
            A_IEN:  rdata = DATA_W'(ien);
            A_FLAG: rdata = DATA_W'(flag);
            default: begin
                for (int m = 0; m < NUM_MT; m++)
                    if (addr == ADDR_W'(A_MLD_BASE + m)) rdata = DATA_W'(mld[m]);
                for (int c = 0; c < NUM_CH; c++)
                    if (addr == ADDR_W'(A_CLD_BASE + c)) rdata = DATA_W'(cld[c]);
            end
        endcase
    end

endmodule

// File: rtl/pit_base.sv
`timescale 1ns/1ps
module pit_base #(
    parameter int MT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            on,
    input  logic            run,
    input  logic            active,
    input  logic            restart,
    input  logic [MT_W-1:0] load,
    output logic            tick,
    output logic [MT_W-1:0] count
);
    logic step;

    assign step = run && active && !restart;
    assign tick = step && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)                   count <= '0;
        else if (!on)              count <= load;
        else if (restart && active) count <= load;
        else if (step)             count <= (count == '0) ? load : count - 1'b1;
    end

endmodule

// File: rtl/pit_chan.sv
`timescale 1ns/1ps
module pit_chan #(
    parameter int CH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            tick,
    input  logic [CH_W-1:0] load,
    output logic            hit,
    output logic [CH_W-1:0] count
);
    assign hit = enable && tick && (count == '0);

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (!enable) count <= load;
        else if (tick)    count <= (count == '0) ? load : count - 1'b1;
    end

endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NUM_MT = 2,
    parameter int MT_W   = 8,
    parameter int CH_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wait_mode,
    input  logic              dbg_freeze,
    output logic [NUM_CH-1:0] irq
);
    localparam int SEL_W = sel_width(NUM_MT);
    localparam int PAD   = 1 << SEL_W;

    ctrl_t                          ctrl_q;
    logic [NUM_CH-1:0]              chen_q, ien_q, flag_q, ch_hit;
    logic [NUM_CH*SEL_W-1:0]        bsel_q;
    logic [NUM_MT-1:0][MT_W-1:0]    mld_q;
    logic [NUM_CH-1:0][CH_W-1:0]    cld_q;
    logic [NUM_MT-1:0]              force_cmd, base_act, base_tick;
    logic [PAD-1:0]                 tick_pad;
    logic                           run;
    logic                           en_q, swai_q, frz_q;
    logic [NUM_MT*MT_W-1:0]         mcnt_flat;
    logic [NUM_CH*CH_W-1:0]         ccnt_flat;

    pit_regs #(.NUM_CH(NUM_CH), .NUM_MT(NUM_MT), .MT_W(MT_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ch_hit(ch_hit), .rdata(rdata), .ctrl(ctrl_q), .chen(chen_q),
        .bsel(bsel_q), .ien(ien_q), .flag(flag_q), .mld(mld_q), .cld(cld_q),
        .force_cmd(force_cmd)
    );

    assign en_q   = ctrl_q.run;
    assign swai_q = ctrl_q.stop_wait;
    assign frz_q  = ctrl_q.frz_stall;
    assign run    = en_q && !(swai_q && wait_mode) && !(frz_q && dbg_freeze);

    always_comb begin
        base_act = '0;
        for (int c = 0; c < NUM_CH; c++)
            for (int m = 0; m < NUM_MT; m++)
                if (chen_q[c] && bsel_q[c*SEL_W +: SEL_W] == SEL_W'(m)) base_act[m] = 1'b1;
    end

    for (genvar m = 0; m < NUM_MT; m++) begin : g_base
        pit_base #(.MT_W(MT_W)) u_base (
            .clk(clk), .rst(rst), .on(en_q), .run(run), .active(base_act[m]),
            .restart(force_cmd[m] && en_q), .load(mld_q[m]),
            .tick(base_tick[m]), .count(mcnt_flat[m*MT_W +: MT_W])
        );
    end

    assign tick_pad = PAD'(base_tick);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pit_chan #(.CH_W(CH_W)) u_chan (
            .clk(clk), .rst(rst), .enable(en_q && chen_q[c]),
            .tick(tick_pad[bsel_q[c*SEL_W +: SEL_W]]), .load(cld_q[c]),
            .hit(ch_hit[c]), .count(ccnt_flat[c*CH_W +: CH_W])
        );
    end

    assign irq = flag_q & ien_q;

endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NUM_MT = 2,
    parameter int MT_W   = 8,
    parameter int CH_W   = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-1:0]      rdata,
    input logic                   wait_mode,
    input logic                   dbg_freeze,
    input logic                   en_q,
    input logic                   swai_q,
    input logic                   frz_q,
    input logic [NUM_CH-1:0]      chen_q,
    input logic [NUM_CH-1:0]      flag_q,
    input logic [NUM_MT*MT_W-1:0] mcnt_flat,
    input logic [NUM_CH*CH_W-1:0] ccnt_flat
);
    a_r2_flags_clear_off: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (flag_q == '0));

    a_r5_flag_needs_chen: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & ~$past(flag_q) & ~$past(chen_q)) == '0));

    a_r10_ctrl_cmd_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTRL) |-> (rdata[4:0] == 5'd0));

    a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (en_q && swai_q && wait_mode && !wr_en) |=> ($stable(mcnt_flat) && $stable(ccnt_flat)));

    a_r7_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (en_q && frz_q && dbg_freeze && !wr_en) |=> ($stable(mcnt_flat) && $stable(ccnt_flat)));

endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH), .NUM_MT(NUM_MT), .MT_W(MT_W), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .wait_mode(wait_mode), .dbg_freeze(dbg_freeze), .en_q(en_q), .swai_q(swai_q),
    .frz_q(frz_q), .chen_q(chen_q), .flag_q(flag_q), .mcnt_flat(mcnt_flat),
    .ccnt_flat(ccnt_flat)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
    import pit_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        wait_mode = 1'b0;
    logic        dbg_freeze = 1'b0;
    logic [3:0]  irq;

    pit_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wait_mode(wait_mode), .dbg_freeze(dbg_freeze), .irq(irq)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [3:0]  a;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    bit    sb_go = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    rise1[4];
    int    rise2[4];
    logic [3:0] irq_d = '0;

    always @(posedge clk) cyc = cyc + 1;

    // monitor: pops one expected item per request and compares with the port
    always @(negedge clk) begin
        if (sb_go) begin
            item_t it;
            logic [15:0] act;
            it = sbq.pop_front();
            act = it.is_irq ? {12'd0, irq} : rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
            end
            sb_go = 1'b0;
        end
    end

    // interrupt edge recorder
    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (irq[c] && !irq_d[c]) begin
                if (rise1[c] < 0)      rise1[c] = cyc;
                else if (rise2[c] < 0) rise2[c] = cyc;
            end
        end
        irq_d = irq;
    end

    task automatic arm();
        for (int c = 0; c < 4; c++) begin
            rise1[c] = -1;
            rise2[c] = -1;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        addr = a;
        sbq.push_back('{1'b0, a, e, tag});
        sb_go = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic [3:0] e, input string tag);
        @(posedge clk); #1;
        sbq.push_back('{1'b1, 4'd0, {12'd0, e}, tag});
        sb_go = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic chk(input string tag, input int act, input int e);
        n_cmp++;
        if (act != e) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, e);
        end
    endtask

    task automatic hold_input(input bit is_wait, input int n);
        if (is_wait) wait_mode = 1'b1; else dbg_freeze = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        wait_mode = 1'b0;
        dbg_freeze = 1'b0;
    endtask

    localparam logic [3:0] A_M0 = 4'(A_MLD_BASE);
    localparam logic [3:0] A_M1 = 4'(A_MLD_BASE + 1);
    localparam logic [3:0] A_C0 = 4'(A_CLD_BASE);
    localparam logic [3:0] A_C1 = 4'(A_CLD_BASE + 1);
    localparam logic [3:0] A_C2 = 4'(A_CLD_BASE + 2);

    initial begin
        int t0;
        arm();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        expect_reg(A_CTRL, 16'h0000, "R1 ctrl");
        expect_reg(A_CHEN, 16'h0000, "R1 chen");
        expect_reg(A_FLAG, 16'h0000, "R1 flag");
        expect_irq(4'b0000, "R1 irq");

        // R10: command bits and reserved bits read zero
        wr(A_CTRL, 16'h007F);
        expect_reg(A_CTRL, 16'h0060, "R10 ctrl readback");
        wr(A_CTRL, 16'h0000);

        // ch0: base0 M=2 N=3 -> 12; ch1: base1 M=0 N=4 -> 5; ch2 left disabled
        wr(A_M0, 16'd2);
        wr(A_M1, 16'd0);
        wr(A_C0, 16'd3);
        wr(A_C1, 16'd4);
        wr(A_C2, 16'd1);
        wr(A_BSEL, 16'b0010);
        wr(A_IEN, 16'b0011);
        wr(A_CHEN, 16'b0011);
        arm();
        wr(A_CTRL, 16'h0080);
        t0 = cyc;
        repeat (14) @(posedge clk);
        chk("R3 first timeout ch0", rise1[0] - t0, 12);
        chk("R3 first timeout ch1", rise1[1] - t0, 5);
        wr(A_FLAG, 16'b0001);
        repeat (12) @(posedge clk);
        chk("R4 period ch0", rise2[0] - rise1[0], 12);
        expect_reg(A_FLAG, 16'b0011, "R5 disabled ch2 no flag");
        expect_irq(4'b0011, "R12 irq both enabled");
        wr(A_IEN, 16'b0001);
        expect_irq(4'b0001, "R12 irq masked ch1");
        wr(A_FLAG, 16'b0000);
        expect_reg(A_FLAG, 16'b0011, "R11 zero write keeps flags");
        wr(A_CHEN, 16'b0001);
        wr(A_FLAG, 16'b0010);
        expect_reg(A_FLAG, 16'b0001, "R11 one clears flag");
        wr(A_CTRL, 16'h0000);
        expect_reg(A_FLAG, 16'h0000, "R2 flags cleared");
        expect_irq(4'b0000, "R2 irq low");

        // R7: freeze stall with control bit set
        arm();
        wr(A_CTRL, 16'h00A0);
        t0 = cyc;
        hold_input(1'b0, 20);
        repeat (16) @(posedge clk);
        chk("R7 freeze delays timeout", rise1[0] - t0, 32);
        wr(A_CTRL, 16'h0000);
        arm();
        wr(A_CTRL, 16'h0080);
        t0 = cyc;
        hold_input(1'b0, 20);
        chk("R7 freeze ignored when bit clear", rise1[0] - t0, 12);
        wr(A_CTRL, 16'h0000);

        // R6: wait stop
        arm();
        wr(A_CTRL, 16'h00C0);
        t0 = cyc;
        hold_input(1'b1, 7);
        repeat (16) @(posedge clk);
        chk("R6 wait delays timeout", rise1[0] - t0, 19);
        wr(A_CTRL, 16'h0000);
        arm();
        wr(A_CTRL, 16'h0080);
        t0 = cyc;
        hold_input(1'b1, 7);
        repeat (10) @(posedge clk);
        chk("R6 wait ignored when bit clear", rise1[0] - t0, 12);
        wr(A_CTRL, 16'h0000);

        // R8 / R9: base restart shifts both channels on base0
        wr(A_M0, 16'd9);
        wr(A_C0, 16'd0);
        wr(A_C2, 16'd1);
        wr(A_BSEL, 16'b0000);
        wr(A_CHEN, 16'b0101);
        wr(A_IEN, 16'b0101);
        arm();
        wr(A_CTRL, 16'h0080);
        t0 = cyc;
        repeat (3) @(posedge clk);
        wr(A_CTRL, 16'h0081);
        repeat (30) @(posedge clk);
        chk("R8 restart delays ch0", rise1[0] - t0, 15);
        chk("R9 restart delays ch2", rise1[2] - t0, 25);
        wr(A_CTRL, 16'h0000);

        // R8: restart of an unused base is ignored
        wr(A_M1, 16'd3);
        wr(A_C1, 16'd0);
        wr(A_BSEL, 16'b0010);
        wr(A_CHEN, 16'b0001);
        wr(A_IEN, 16'b0011);
        wr(A_CTRL, 16'h0080);
        wr(A_M1, 16'd7);
        wr(A_CTRL, 16'h0082);
        arm();
        wr(A_CHEN, 16'b0011);
        t0 = cyc;
        repeat (12) @(posedge clk);
        chk("R8 unused base restart ignored", rise1[1] - t0, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule